// File: doc/BRIEF.md
# Flag-Based Magnitude Comparator

This block orders two W-bit operands, A and B, without a dedicated comparator tree. It subtracts A from B with one adder, computing B + ~A with the carry-in held at 1. The ordering is then read from the adder's condition flags. Those flags are carry, zero, negative, overflow and the signed sign bit. From them the block reports whether B is below, equal to or above A, under unsigned or two's-complement rules as a mode input selects.

The raw flags are exported beside the decoded result, so a surrounding datapath can reuse them. Equality is also formed on a second, independent path. That path XNORs the operands bit by bit and then detects all ones. The block also reports whether operand A is all ones or all zeros.

The logic is purely combinational and has no clock. The width is a parameter, from 2 to 64, with a default of 8. A second parameter picks the adder variant: an explicit ripple chain of full adders, or an inferred add.

Top module: `flag_cmp`

## Requirements
- R1: `diff` equals (B − A) modulo 2^W, formed as B + ~A + 1 with the adder carry-in at 1.
- R2: `flag_c` is the adder carry-out: it is 1 exactly when B ≥ A as unsigned numbers and 0 when B < A.
- R3: `flag_z` is 1 exactly when every bit of `diff` is 0, that is when A equals B.
- R4: `flag_n` equals the most significant bit of `diff`.
- R5: `flag_v` is 1 exactly when B and ~A have the same top bit and the top bit of `diff` differs from it, that is when the signed B − A overflows.
- R6: `flag_s` equals `flag_n` xor `flag_v`, and it is 1 exactly when B < A as two's-complement numbers.
- R7: `eq_bitwise` comes from a bitwise XNOR of A and B followed by an all-ones detect, and it is 1 exactly when A equals B.
- R8: `a_ones` is 1 exactly when every bit of A is 1 (a W-input AND). `a_zeros` is 1 exactly when every bit of A is 0 (a W-input NOR).
- R9: With `signed_mode` at 0, `b_lt_a` is `~flag_c`, `b_eq_a` is `flag_z`, and `b_gt_a` is 1 when neither of the other two is 1. Together they give the unsigned order of B against A.
- R10: With `signed_mode` at 1, `b_lt_a` is `flag_s`, `b_eq_a` is `flag_z`, and `b_gt_a` is 1 when neither of the other two is 1. Together they give the two's-complement order of B against A.
- R11: Exactly one of `b_lt_a`, `b_eq_a` and `b_gt_a` is 1 for every pair of operands in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Operand A, the subtrahend |
| op_b | input | W | Operand B, the minuend |
| signed_mode | input | 1 | 1 selects two's-complement ordering, 0 selects unsigned ordering |
| diff | output | W | B − A modulo 2^W |
| flag_c | output | 1 | Adder carry-out |
| flag_z | output | 1 | Difference is zero |
| flag_n | output | 1 | Top bit of the difference |
| flag_v | output | 1 | Signed overflow of B − A |
| flag_s | output | 1 | flag_n xor flag_v |
| eq_bitwise | output | 1 | Equality from the XNOR path |
| a_ones | output | 1 | A is all ones |
| a_zeros | output | 1 | A is all zeros |
| b_lt_a | output | 1 | B below A in the selected mode |
| b_eq_a | output | 1 | B equals A |
| b_gt_a | output | 1 | B above A in the selected mode |

## Verification
The block holds no state, so any fault in the carry chain, the zero tree or the flag decode shows at the ports as soon as the operands settle. Such a fault shows only for the operand pairs that exercise it. For example, a broken carry link between two bits appears only when a borrow has to cross it. A wrong overflow term appears only where the operand signs differ. For this reason every operand pair is applied in both modes at 8 bits and at 4 bits. Each output is compared with native unsigned and signed arithmetic, so that no fault can hide behind an untested pattern.

// File: rtl/flagcmp_pkg.sv
package flagcmp_pkg;

   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 64;

   typedef enum logic {
      ADD_RIPPLE = 1'b0,
      ADD_INFER  = 1'b1
   } adder_style_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
      logic s;
   } cond_flags_t;

endpackage

// File: rtl/flagcmp_and_tree.sv
module flagcmp_and_tree #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             all_o
);
   localparam int unsigned LEVELS = (WIDTH < 2) ? 1 : $clog2(WIDTH);
   localparam int unsigned LEAVES = 1 << LEVELS;

   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("flagcmp_and_tree: WIDTH out of range");
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int unsigned NODES = LEAVES >> l;
      logic [NODES-1:0] v;
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < NODES; i++) begin : g_in
            if (i < WIDTH) begin : g_real
               assign v[i] = bits_i[i];
            end else begin : g_pad
               assign v[i] = 1'b1;
            end
         end
      end else begin : g_node
         for (genvar j = 0; j < NODES; j++) begin : g_and
            assign v[j] = g_lvl[l-1].v[2*j] & g_lvl[l-1].v[2*j+1];
         end
      end
   end

   assign all_o = g_lvl[LEVELS].v[0];

   // R8: the tree must agree with a flat reduction of its inputs
   always_comb begin
      a_r8_tree_reduce: assert (all_o == (&bits_i))
         else $error("and tree disagrees with flat reduction");
   end

endmodule

// File: rtl/flagcmp_sub.sv
module flagcmp_sub
   import flagcmp_pkg::*;
#(
   parameter int unsigned  WIDTH       = 8,
   parameter adder_style_e ADDER_STYLE = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] diff_o,
   output logic             carry_o,
   output logic             ovf_o
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("flagcmp_sub: WIDTH out of range");
   end

   logic [WIDTH-1:0] a_inv;
   assign a_inv = ~a_i;

   if (ADDER_STYLE == ADD_RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = 1'b1;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign diff_o[i] = b_i[i] ^ a_inv[i] ^ cy[i];
         assign cy[i+1]   = (b_i[i] & a_inv[i]) | (cy[i] & (b_i[i] ^ a_inv[i]));
      end
      assign carry_o = cy[WIDTH];

      // R5: overflow from operand signs must match the top two carries
      always_comb begin
         a_r5_carry_pair: assert (ovf_o == (cy[WIDTH] ^ cy[WIDTH-1]))
            else $error("overflow disagrees with carry pair");
      end
   end else begin : g_infer
      logic [WIDTH:0] wide_sum;
      assign wide_sum = {1'b0, b_i} + {1'b0, a_inv} + {{WIDTH{1'b0}}, 1'b1};
      assign diff_o   = wide_sum[WIDTH-1:0];
      assign carry_o  = wide_sum[WIDTH];
   end

   assign ovf_o = (b_i[MSB] == a_inv[MSB]) && (diff_o[MSB] != b_i[MSB]);

   // R1: the sum must be the modular difference
   // R5: signed overflow only when the original operands differ in sign
   always_comb begin
      a_r1_difference: assert (diff_o == WIDTH'(b_i - a_i))
         else $error("difference wrong");
      a_r5_no_overflow: assert (!ovf_o || (a_i[MSB] != b_i[MSB]))
         else $error("overflow with like-signed operands");
   end

endmodule

// File: rtl/flagcmp_order.sv
module flagcmp_order
   import flagcmp_pkg::*;
(
   input  cond_flags_t flags_i,
   input  logic        signed_mode_i,
   output logic        lt_o,
   output logic        eq_o,
   output logic        gt_o
);
   always_comb begin
      eq_o = flags_i.z;
      lt_o = signed_mode_i ? flags_i.s : ~flags_i.c;
      gt_o = ~lt_o & ~eq_o;
   end

   // R11: exactly one ordering; zero difference must never read as below
   always_comb begin
      a_r11_one_order: assert ($onehot({lt_o, eq_o, gt_o}))
         else $error("ordering outputs not one-hot");
      a_r9_zero_carries: assert (!flags_i.z || flags_i.c)
         else $error("zero difference without carry-out");
      a_r10_zero_positive: assert (!flags_i.z || !flags_i.s)
         else $error("zero difference with sign set");
   end

endmodule

// File: rtl/flag_cmp.sv
module flag_cmp
   import flagcmp_pkg::*;
#(
   parameter int unsigned  WIDTH       = 8,
   parameter adder_style_e ADDER_STYLE = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             signed_mode,
   output logic [WIDTH-1:0] diff,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_v,
   output logic             flag_s,
   output logic             eq_bitwise,
   output logic             a_ones,
   output logic             a_zeros,
   output logic             b_lt_a,
   output logic             b_eq_a,
   output logic             b_gt_a
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("flag_cmp: WIDTH must lie in 2..64");
   end

   cond_flags_t      flags;
   logic [WIDTH-1:0] diff_zero_bits;
   logic [WIDTH-1:0] match_bits;
   logic [WIDTH-1:0] a_low_bits;

   flagcmp_sub #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_sub (
      .a_i     (op_a),
      .b_i     (op_b),
      .diff_o  (diff),
      .carry_o (flags.c),
      .ovf_o   (flags.v)
   );

   assign diff_zero_bits = ~diff;
   assign match_bits     = ~(op_a ^ op_b);
   assign a_low_bits     = ~op_a;

   flagcmp_and_tree #(.WIDTH(WIDTH)) u_zero_tree (
      .bits_i (diff_zero_bits),
      .all_o  (flags.z)
   );

   flagcmp_and_tree #(.WIDTH(WIDTH)) u_match_tree (
      .bits_i (match_bits),
      .all_o  (eq_bitwise)
   );

   flagcmp_and_tree #(.WIDTH(WIDTH)) u_ones_tree (
      .bits_i (op_a),
      .all_o  (a_ones)
   );

   flagcmp_and_tree #(.WIDTH(WIDTH)) u_zeros_tree (
      .bits_i (a_low_bits),
      .all_o  (a_zeros)
   );

   assign flags.n = diff[MSB];
   assign flags.s = flags.n ^ flags.v;

   flagcmp_order u_order (
      .flags_i       (flags),
      .signed_mode_i (signed_mode),
      .lt_o          (b_lt_a),
      .eq_o          (b_eq_a),
      .gt_o          (b_gt_a)
   );

   assign flag_c = flags.c;
   assign flag_z = flags.z;
   assign flag_n = flags.n;
   assign flag_v = flags.v;
   assign flag_s = flags.s;

   // R2, R3, R6, R7, R8: flags must match native ordering and the XNOR path
   always_comb begin
      a_r2_carry_order: assert (flag_c == (op_b >= op_a))
         else $error("carry does not give unsigned order");
      a_r7_paths_agree: assert (eq_bitwise == flag_z)
         else $error("xnor equality and zero flag disagree");
      a_r3_zero_equal: assert (flag_z == (op_a == op_b))
         else $error("zero flag wrong");
      a_r6_signed_order: assert (flag_s == ($signed(op_b) < $signed(op_a)))
         else $error("sign flag does not give signed order");
      a_r8_detect_excl: assert (!(a_ones && a_zeros))
         else $error("operand both all ones and all zeros");
   end

endmodule

// File: tb/flag_cmp_tb.sv
module flag_cmp_tb;
   import flagcmp_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   // width 8, ripple adder
   logic [7:0] a8, b8, d8;
   logic       m8;
   logic       c8, z8, n8, v8, s8, xe8, on8, ze8, lt8, eq8, gt8;

   flag_cmp #(.WIDTH(8), .ADDER_STYLE(ADD_RIPPLE)) u_dut (
      .op_a(a8), .op_b(b8), .signed_mode(m8), .diff(d8),
      .flag_c(c8), .flag_z(z8), .flag_n(n8), .flag_v(v8), .flag_s(s8),
      .eq_bitwise(xe8), .a_ones(on8), .a_zeros(ze8),
      .b_lt_a(lt8), .b_eq_a(eq8), .b_gt_a(gt8)
   );

   // width 4, inferred adder
   logic [3:0] a4, b4, d4;
   logic       m4;
   logic       c4, z4, n4, v4, s4, xe4, on4, ze4, lt4, eq4, gt4;

   flag_cmp #(.WIDTH(4), .ADDER_STYLE(ADD_INFER)) u_dut_w4 (
      .op_a(a4), .op_b(b4), .signed_mode(m4), .diff(d4),
      .flag_c(c4), .flag_z(z4), .flag_n(n4), .flag_v(v4), .flag_s(s4),
      .eq_bitwise(xe4), .a_ones(on4), .a_zeros(ze4),
      .b_lt_a(lt4), .b_eq_a(eq4), .b_gt_a(gt4)
   );

   task automatic chk(string req, string what, longint act, longint exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected values from native arithmetic, compared field by field
   task automatic verify(int w, longint a, longint b, bit sm, longint d,
                         bit c, bit z, bit n, bit v, bit s, bit xe,
                         bit on, bit ze, bit lt, bit eq, bit gt);
      longint mask = (longint'(1) << w) - 1;
      longint half = longint'(1) << (w - 1);
      longint sa   = (a >= half) ? a - (mask + 1) : a;
      longint sb   = (b >= half) ? b - (mask + 1) : b;
      longint sd   = sb - sa;
      longint ed   = (b - a) & mask;
      bit     ev   = (sd < -half) || (sd > half - 1);
      bit     es   = sb < sa;
      bit     elt  = sm ? es : (b < a);
      bit     eeq  = (a == b);
      chk("R1", "diff", d, ed);
      chk("R2", "flag_c", longint'(c), longint'(b >= a));
      chk("R3", "flag_z", longint'(z), longint'(eeq));
      chk("R4", "flag_n", longint'(n), (ed >> (w - 1)) & 1);
      chk("R5", "flag_v", longint'(v), longint'(ev));
      chk("R6", "flag_s", longint'(s), longint'(es));
      chk("R7", "eq_bitwise", longint'(xe), longint'(eeq));
      chk("R8", "a_ones", longint'(on), longint'(a == mask));
      chk("R8", "a_zeros", longint'(ze), longint'(a == 0));
      chk(sm ? "R10" : "R9", "b_lt_a", longint'(lt), longint'(elt));
      chk(sm ? "R10" : "R9", "b_eq_a", longint'(eq), longint'(eeq));
      chk(sm ? "R10" : "R9", "b_gt_a", longint'(gt), longint'(!elt && !eeq));
      chk("R11", "one-hot order", longint'(lt) + longint'(eq) + longint'(gt), 1);
   endtask

   task automatic apply8(longint a, longint b, bit sm);
      a8 = a[7:0]; b8 = b[7:0]; m8 = sm;
      #10;
      verify(8, a, b, sm, longint'(d8), c8, z8, n8, v8, s8, xe8, on8, ze8, lt8, eq8, gt8);
   endtask

   task automatic apply4(longint a, longint b, bit sm);
      a4 = a[3:0]; b4 = b[3:0]; m4 = sm;
      #10;
      verify(4, a, b, sm, longint'(d4), c4, z4, n4, v4, s4, xe4, on4, ze4, lt4, eq4, gt4);
   endtask

   task automatic t_idle_state();
      // both operands zero: equal, carry out, A all zeros
      apply8(0, 0, 1'b0);
      chk("R3", "idle b_eq_a", longint'(eq8), 1);
      chk("R2", "idle flag_c", longint'(c8), 1);
      chk("R8", "idle a_zeros", longint'(ze8), 1);
   endtask

   task automatic t_corners();
      // B=0x7F, A=0x80: signed 127-(-128) overflows, diff 0xFF, signed B above A
      apply8(128, 127, 1'b1);
      chk("R5", "corner flag_v", longint'(v8), 1);
      chk("R10", "corner signed gt", longint'(gt8), 1);
      apply8(128, 127, 1'b0);
      chk("R9", "corner unsigned lt", longint'(lt8), 1);
      // A all ones
      apply8(255, 0, 1'b0);
      chk("R8", "corner a_ones", longint'(on8), 1);
      chk("R4", "corner flag_n", longint'(n8), 0);
   endtask

   task automatic t_exhaustive8(bit sm);
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            apply8(longint'(a), longint'(b), sm);
   endtask

   task automatic t_exhaustive4();
      for (int sm = 0; sm < 2; sm++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               apply4(longint'(a), longint'(b), sm[0]);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles > 150000) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      a8 = '0; b8 = '0; m8 = 1'b0;
      a4 = '0; b4 = '0; m4 = 1'b0;
      #5;
      t_idle_state();
      t_corners();
      t_exhaustive8(1'b0);
      t_exhaustive8(1'b1);
      t_exhaustive4();
      if (!done) begin
         done = 1'b1;
         finish_run();
      end
   end

endmodule